// File: doc/BRIEF.md
# Slot-Ranked Interrupt Controller

This block gathers up to 32 interrupt lines into a pending vector, filters them through a software mask and chooses one winner to report to the processor. Software sees it as a small word-addressed register file on a 32-bit bus. In every source-indexed register, source `b` lives at register bit `31-b`.

Ranking is not done by giving each source a numeric level. Each group of eight sources has one priority register with eight 3-bit slot fields. Software places a group-local source code in a slot, and lower slots rank higher. Per group, a mode bit chooses how groups combine:

- **Grouped mode:** a whole group outranks the next group.
- **Spread mode:** slots from different groups interleave.

A source whose code sits in no slot, or that belongs to no group, ranks below every slotted source. An override field can lift one source above all of them.

A few sources are external inputs, and each can be made edge-sensitive. All inputs pass through a two-flop synchroniser before they reach the pending logic. The winning source number is kept in a vector register, and a single request line goes to the processor.

Top module: `slotirq_ctrl`

## Requirements
- R1: After reset, every readable register returns zero and `irq_o` is low.
- R2: A source whose mask bit is 0 never raises `irq_o` or appears in the vector. The mask register sits at word 1, and source `b` uses bit `31-b`.
- R3: A level-sensed source's pending bit follows its synchronised input. Writing 1 to that pending bit (word 0) while the input is high leaves the bit set, and the bit drops when the input goes low.
- R4: External input `i` is source `EXT_BASE+i`. When the sense register (word 3) has bit `15-i` set to 1, the input is edge-sensed:
  - a rising edge sets its pending bit;
  - the bit stays set after the input falls;
  - writing 1 to its bit in word 0 clears it.
- R5: `irq_o` is high exactly when some source with index 1 or above is both pending and unmasked.
- R6: Word 4 returns the winning source number in bits 6:0, and 0 when no unmasked source is pending.
- R7: Priority register for group `g` is at word `8+g`. Its slot `s` is a 3-bit field at bit offset:
  - `20+(3-s)*3` for slots 0 to 3;
  - `4+(7-s)*3` for slots 4 to 7.
  The field holds code `c`, which names source `GROUP_BASE+8g+c`. A lower slot wins within a group.
- R8: In grouped mode, any slotted source of a lower-numbered group beats every source of a higher-numbered group.
- R9: When bit `g` of the configuration register (word 2) is 1, group `g` is in spread mode. Among spread groups, a lower slot wins first; on an equal slot, the lower group wins.
- R10: Some sources rank below every slotted source:
  - group sources whose code appears in no slot;
  - sources outside any group.
  Among these, the lowest source number wins.
- R11: A code that appears in several slots takes the best of those slots.
- R12: Bits 30:24 of word 2 name an override source. When that source is pending and unmasked, it wins over every ranking. A value of 0, or a value naming an inactive source, has no effect.
- R13: `irq_o` and the vector change one clock after a mask, priority or configuration write. A pending bit changes three clocks after its input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Interrupt lines, bit n is source n (bit 0 unused) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume the following:
- The block starts under reset.
- Source 0 is never driven high.
- Edge pulses on external lines last at least two clocks, so the synchroniser can see them.
- The override field names a source below 32 whenever it should take effect.

The stimulus keeps to these limits. Every input change is held for several cycles before sampling, and only the sources in each table row are raised.

// File: rtl/slotirq_pkg.sv
package slotirq_pkg;
  localparam int SRC_N  = 32;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 7;
  localparam int SLOTS  = 8;
  localparam int CODE_W = 3;

  // Word addresses
  localparam int A_PEND  = 0;
  localparam int A_MASK  = 1;
  localparam int A_CFG   = 2;
  localparam int A_SENSE = 3;
  localparam int A_VEC   = 4;
  localparam int A_PRIO  = 8;

  localparam int OVR_LSB = 24;

  // Register bit (31-b) carries source b.
  function automatic logic [DATA_W-1:0] msb_map(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[DATA_W-1-i] = v[i];
    return r;
  endfunction

  // Bit offset of slot s inside a priority register
  function automatic int slot_lsb(input int s);
    return (s < 4) ? 20 + (3 - s) * 3 : 4 + (7 - s) * 3;
  endfunction
endpackage

// File: rtl/slotirq_pend.sv
module slotirq_pend
  import slotirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_i,
  input  logic [SRC_N-1:0] edge_sel_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] pend_o
);
  logic [SRC_N-1:0] s1_q, s2_q, s3_q, pend_q, pend_d;

  always_comb begin
    for (int i = 0; i < SRC_N; i++) begin
      if (edge_sel_i[i]) pend_d[i] = (pend_q[i] & ~clr_i[i]) | (s2_q[i] & ~s3_q[i]);
      else               pend_d[i] = s2_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      pend_q <= '0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < SRC_N; i++) begin : g_chk
    // R4: an edge-sensed bit cleared with no new rising edge is low next cycle
    assert_edge_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel_i[i] && clr_i[i] && !(s2_q[i] && !s3_q[i])) |=> !pend_o[i]);
  end
endmodule

// File: rtl/slotirq_rank.sv
module slotirq_rank
  import slotirq_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int GROUP_BASE = 8
)(
  input  logic [SRC_N-1:0]      active_i,
  input  logic [DATA_W-1:0]     prio_i [NUM_GROUPS],
  input  logic [NUM_GROUPS-1:0] spread_i,
  input  logic [VEC_W-1:0]      ovr_i,
  output logic [VEC_W-1:0]      win_o,
  output logic                  ovr_hit_o
);
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int KW = GW + CODE_W + 1;
  localparam logic [KW-1:0] UNR_KEY = {1'b1, {(KW-1){1'b0}}};

  logic [KW-1:0] key [SRC_N];

  // Rank key per source: smaller wins
  always_comb begin
    logic hit;
    logic [CODE_W-1:0] sl;
    for (int n = 0; n < SRC_N; n++) key[n] = UNR_KEY;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int c = 0; c < SLOTS; c++) begin
        hit = 1'b0;
        sl  = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
          if (prio_i[g][slot_lsb(s) +: CODE_W] == CODE_W'(c)) begin
            hit = 1'b1;
            sl  = CODE_W'(s);
          end
        end
        if (hit)
          key[GROUP_BASE + SLOTS * g + c] = spread_i[g] ? {1'b0, sl, GW'(g)}
                                                       : {1'b0, GW'(g), sl};
      end
    end
  end

  // Winner scan; ascending order breaks ties toward the lower number
  always_comb begin
    logic any;
    logic [KW-1:0] best;
    any  = 1'b0;
    best = UNR_KEY;
    win_o = '0;
    for (int n = 1; n < SRC_N; n++) begin
      if (active_i[n] && (!any || key[n] < best)) begin
        any   = 1'b1;
        best  = key[n];
        win_o = VEC_W'(n);
      end
    end
    ovr_hit_o = (ovr_i != '0) && (ovr_i[VEC_W-1:5] == '0) && active_i[ovr_i[4:0]];
    if (ovr_hit_o) win_o = ovr_i;
  end
endmodule

// File: rtl/slotirq_ctrl.sv
module slotirq_ctrl
  import slotirq_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int GROUP_BASE = 8,
  parameter int NUM_EXT    = 4,
  parameter int EXT_BASE   = 24,
  parameter int ADDR_W     = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rs1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  logic [SRC_N-1:0]      mask_q, mask_d, pend, active, edge_sel, clr;
  logic [DATA_W-1:0]     prio_q [NUM_GROUPS];
  logic [DATA_W-1:0]     prio_d [NUM_GROUPS];
  logic [VEC_W-1:0]      ovr_q, ovr_d, win, vec_q;
  logic [NUM_GROUPS-1:0] spread_q, spread_d;
  logic [NUM_EXT-1:0]    sense_q, sense_d;
  logic                  irq_q, ovr_hit;

  logic wr_pend, wr_mask, wr_cfg, wr_sense;
  assign wr_pend  = wr_en && (addr == ADDR_W'(A_PEND));
  assign wr_mask  = wr_en && (addr == ADDR_W'(A_MASK));
  assign wr_cfg   = wr_en && (addr == ADDR_W'(A_CFG));
  assign wr_sense = wr_en && (addr == ADDR_W'(A_SENSE));

  // Next-state logic
  always_comb begin
    mask_d   = wr_mask  ? msb_map(wdata) : mask_q;
    ovr_d    = wr_cfg   ? wdata[OVR_LSB +: VEC_W] : ovr_q;
    spread_d = wr_cfg   ? wdata[NUM_GROUPS-1:0] : spread_q;
    sense_d  = sense_q;
    if (wr_sense)
      for (int i = 0; i < NUM_EXT; i++) sense_d[i] = wdata[15 - i];
    for (int g = 0; g < NUM_GROUPS; g++)
      prio_d[g] = (wr_en && addr == ADDR_W'(A_PRIO + g)) ? wdata : prio_q[g];
    clr = wr_pend ? msb_map(wdata) : '0;
    edge_sel = '0;
    for (int i = 0; i < NUM_EXT; i++) edge_sel[EXT_BASE + i] = sense_q[i];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mask_q   <= '0;
      ovr_q    <= '0;
      spread_q <= '0;
      sense_q  <= '0;
      vec_q    <= '0;
      irq_q    <= 1'b0;
      for (int g = 0; g < NUM_GROUPS; g++) prio_q[g] <= '0;
    end else begin
      mask_q   <= mask_d;
      ovr_q    <= ovr_d;
      spread_q <= spread_d;
      sense_q  <= sense_d;
      vec_q    <= win;
      irq_q    <= |active[SRC_N-1:1];
      for (int g = 0; g < NUM_GROUPS; g++) prio_q[g] <= prio_d[g];
    end
  end

  slotirq_pend u_pend (
    .clk        (clk),
    .rst_n      (rst_s),
    .src_i      (src_i),
    .edge_sel_i (edge_sel),
    .clr_i      (clr),
    .pend_o     (pend)
  );

  assign active = pend & mask_q & ~SRC_N'(1);

  slotirq_rank #(.NUM_GROUPS(NUM_GROUPS), .GROUP_BASE(GROUP_BASE)) u_rank (
    .active_i  (active),
    .prio_i    (prio_q),
    .spread_i  (spread_q),
    .ovr_i     (ovr_q),
    .win_o     (win),
    .ovr_hit_o (ovr_hit)
  );

  // Read mux
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_PEND))  rdata = msb_map(pend);
    if (addr == ADDR_W'(A_MASK))  rdata = msb_map(mask_q);
    if (addr == ADDR_W'(A_CFG)) begin
      rdata[OVR_LSB +: VEC_W]    = ovr_q;
      rdata[NUM_GROUPS-1:0]      = spread_q;
    end
    if (addr == ADDR_W'(A_SENSE))
      for (int i = 0; i < NUM_EXT; i++) rdata[15 - i] = sense_q[i];
    if (addr == ADDR_W'(A_VEC))   rdata[VEC_W-1:0] = vec_q;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (addr == ADDR_W'(A_PRIO + g)) rdata = prio_q[g];
  end

  assign irq_o = irq_q;

  // R6: idle request means empty vector, and a request always names a source
  assert_idle_vec_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !irq_o |-> (vec_q == '0));
  assert_req_vec_R5: assert property (@(posedge clk) disable iff (!rst_s)
    irq_o |-> (vec_q != '0));
  // R2: with every source masked the request stays low
  assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_q == '0) |=> !irq_o);
  // R12: a live override source is what the vector reports
  assert_override_wins_R12: assert property (@(posedge clk) disable iff (!rst_s)
    ovr_hit |=> (vec_q == $past(ovr_q)));
endmodule

// File: tb/tb_slotirq_ctrl.sv
module tb_slotirq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_i;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slotirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] src;    // bit n = source n
    logic [31:0] mask;   // bit n = source n
    logic [23:0] p0;     // slot codes, slot 0 in the top 3 bits
    logic [23:0] p1;
    logic [1:0]  spread;
    logic [6:0]  ovr;
    logic [6:0]  exp;
  } row_t;

  localparam row_t TBL [12] = '{
    '{32'h0010_0200, 32'hFFFF_FFFF, 24'o01234567, 24'o01234567, 2'b00, 7'd0,  7'd9},  // R8
    '{32'h0002_0400, 32'hFFFF_FFFF, 24'o01234567, 24'o01234567, 2'b00, 7'd0,  7'd10}, // R8
    '{32'h0002_0400, 32'hFFFF_FFFF, 24'o01234567, 24'o01234567, 2'b11, 7'd0,  7'd17}, // R9
    '{32'h0000_8100, 32'hFFFF_FFFF, 24'o76543210, 24'o01234567, 2'b00, 7'd0,  7'd15}, // R7
    '{32'h0000_8100, 32'hFFFF_7FFF, 24'o76543210, 24'o01234567, 2'b00, 7'd0,  7'd8},  // R2
    '{32'h0000_0108, 32'hFFFF_FFFF, 24'o00000000, 24'o00000000, 2'b00, 7'd0,  7'd8},  // R10
    '{32'h4000_1020, 32'hFFFF_FFFF, 24'o00000000, 24'o00000000, 2'b00, 7'd0,  7'd5},  // R10
    '{32'h4000_1020, 32'hFFFF_FFFF, 24'o00000000, 24'o00000000, 2'b00, 7'd30, 7'd30}, // R12
    '{32'h4000_1020, 32'hFFFF_FFFF, 24'o00000000, 24'o00000000, 2'b00, 7'd29, 7'd5},  // R12
    '{32'h0000_0C00, 32'hFFFF_FFFF, 24'o32300000, 24'o00000000, 2'b00, 7'd0,  7'd11}, // R11
    '{32'h0000_0000, 32'hFFFF_FFFF, 24'o01234567, 24'o01234567, 2'b00, 7'd0,  7'd0},  // R6
    '{32'h0000_0200, 32'h0000_0000, 24'o01234567, 24'o01234567, 2'b00, 7'd0,  7'd0}   // R2
  };

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31 - i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] mkprio(input logic [23:0] codes);
    logic [31:0] r;
    int lsb;
    r = '0;
    for (int s = 0; s < 8; s++) begin
      lsb = (s < 4) ? 20 + (3 - s) * 3 : 4 + (7 - s) * 3;
      r[lsb +: 3] = codes[21 - 3 * s +: 3];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_i = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check("R1 register reset", d, 32'h0);
    end
    check("R1 irq reset", {31'b0, irq_o}, 32'h0);

    // R2 MSB-first mask layout
    wr(4'd1, rev32(32'h0000_0200));
    rd(4'd1, d);
    check("R2 mask bit 31-b", d, 32'h0040_0000);

    // Table walk: R2 R5 R6 R7 R8 R9 R10 R11 R12
    for (int k = 0; k < 12; k++) begin
      wr(4'd1, rev32(TBL[k].mask));
      wr(4'd8, mkprio(TBL[k].p0));
      wr(4'd9, mkprio(TBL[k].p1));
      wr(4'd2, {1'b0, TBL[k].ovr, 22'b0, TBL[k].spread});
      src_i = TBL[k].src;
      idle(6);
      rd(4'd4, d);
      check($sformatf("R6 table row %0d vector", k), d, {25'b0, TBL[k].exp});
      check($sformatf("R5 table row %0d irq", k), {31'b0, irq_o}, {31'b0, TBL[k].exp != 0});
    end
    rd(4'd2, d);
    check("R12 cfg readback", d, 32'h0000_0000);

    src_i = '0;
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h0);
    wr(4'd2, 32'h0);
    wr(4'd1, 32'hFFFF_FFFF);
    idle(5);

    // R4 edge sense on external input 0 (source 24)
    wr(4'd3, 32'h0000_8000);
    rd(4'd3, d);
    check("R4 sense readback", d, 32'h0000_8000);
    src_i[24] = 1'b1;
    idle(2);
    src_i[24] = 1'b0;
    idle(6);
    rd(4'd0, d);
    check("R4 edge pending held", d, 32'h0000_0080);
    rd(4'd4, d);
    check("R4 edge vector", d, 32'd24);
    wr(4'd0, 32'h0000_0080);
    idle(2);
    rd(4'd0, d);
    check("R4 edge cleared", d, 32'h0);
    check("R4 irq after clear", {31'b0, irq_o}, 32'h0);

    // R3 level sense on source 25: clear write ignored while high
    src_i[25] = 1'b1;
    idle(6);
    wr(4'd0, 32'h0000_0040);
    idle(2);
    rd(4'd0, d);
    check("R3 level ignores clear", d, 32'h0000_0040);
    src_i[25] = 1'b0;
    idle(5);
    rd(4'd0, d);
    check("R3 level drops with input", d, 32'h0);

    // R13 latency from mask write
    wr(4'd1, 32'h0);
    src_i[28] = 1'b1;
    idle(6);
    check("R13 masked pending no irq", {31'b0, irq_o}, 32'h0);
    wr(4'd1, rev32(32'h1000_0000));
    check("R13 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R13 irq one cycle later", {31'b0, irq_o}, 32'h1);
    rd(4'd4, d);
    check("R13 vector one cycle later", d, 32'd28);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule